// File: doc/BRIEF.md
# Outbound MMIO Window Partition Decoder

This block classifies CPU-side MMIO addresses for a host bridge. It matches each request address against one translating window that emits 32-bit bus addresses and against sixteen pass-through windows for 64-bit addresses. It returns whether the address hit, which window claimed it, the bus address to put on PCIe and the isolation partition number that owns the access.

Every window is a naturally aligned power-of-two range. The translating window keeps the address bits below its size and fills the upper bits of the 32-bit bus address from a configured value. It splits its range into 256 equal segments, and a 256-entry table gives each segment a partition. A pass-through window either gives its whole range one configured partition or, when segmented, uses its 256-way segment index directly as the partition. When windows overlap, the translating window has priority, followed by the pass-through windows in ascending index order.

Configuration arrives on a single-cycle register write port. Lookups pass through a three-state controller. In IDLE, a request is accepted and the controller moves to DECODE. DECODE evaluates all windows, registers the winner and always moves to REPLY. REPLY presents the result for one cycle and always returns to IDLE.

Top module: `mmio_part_decoder`

## Requirements
- R1: After reset, every window is disabled and every table entry is 0. `req_ready` is 1, `resp_valid` is 0, and any lookup misses.
- R2: A request is accepted only while `req_ready` is 1. `resp_valid` is high for exactly one cycle, two clock edges after acceptance. `req_ready` stays 0 until after that cycle, and `req_valid` is ignored while `req_ready` is 0.
- R3: For a hit in the translating window of size 2^L, the bus address is zero-extended to 64 bits. Bits [L-1:0] come from the request, and bits [31:L] come from bits [31:L] of the configured upper value.
- R4: For a hit in the translating window, the partition is table entry `addr[L-1:L-8]`.
- R5: A written translating-window size exponent is clamped into the range 16 to 32.
- R6: For a hit in a pass-through window, the bus address is the request address zero-extended to 64 bits.
- R7: For a segmented pass-through window of size 2^L, the partition is `addr[L-1:L-8]`.
- R8: An unsegmented pass-through window returns its configured partition for every address in its range.
- R9: A written pass-through size exponent is clamped into the range 28 to 50.
- R10: When windows overlap, the translating window (`resp_win`=0) wins, then the lowest-numbered pass-through window n (`resp_win`=n+1).
- R11: A miss returns `resp_hit`=0, with `resp_win`, `resp_pe` and `resp_bus_addr` all 0.
- R12: Base bits below a window's size are ignored. Only bits at and above the size exponent are compared.
- R13: A disabled window never hits. The lookup falls through to the next window in priority order.

Configuration map (`cfg_addr`, 10 bits):
- 0x000–0x0FF: table entry, with the partition in `cfg_wdata[7:0]`.
- 0x100: translating-window base.
- 0x101: translating-window control. Bit [0] is enable, bits [13:8] are the size exponent, and bits [63:32] are the upper value.
- 0x200|(n<<1): pass-through window n base.
- 0x201|(n<<1): pass-through window n control. Bit [0] is enable, bit [1] is segmented, bits [13:8] are the size exponent, and bits [23:16] are the partition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Configuration register select |
| cfg_wdata | input | 64 | Configuration write data |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 50 | CPU address to decode |
| req_ready | output | 1 | Controller idle, request will be taken |
| resp_valid | output | 1 | Result present (one cycle) |
| resp_hit | output | 1 | Address claimed by a window |
| resp_win | output | 5 | 0 for the translating window, n+1 for pass-through window n |
| resp_pe | output | 8 | Owning partition number |
| resp_bus_addr | output | 64 | Address for the PCIe side |

## Verification
The hardest situation to reach is an overlap in which the winner is decided by priority. It needs an address that three windows claim at once: the translating window, a lower-numbered unsegmented pass-through window and a higher-numbered segmented one. The stimulus builds this up one window at a time. It checks that each newly enabled window takes over, then disables the middle window and picks an address outside the translating range, so the lookup has to fall through to the segmented window. Size clamping is reached by writing out-of-range exponents and probing addresses on either side of the clamped edge.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_REPLY  = 2'd2
    } dec_state_e;

    localparam logic [1:0] SPACE_TBL = 2'b00;
    localparam logic [1:0] SPACE_W32 = 2'b01;
    localparam logic [1:0] SPACE_W64 = 2'b10;

endpackage

// File: rtl/mmio_win_regs.sv
module mmio_win_regs
    import mmio_dec_pkg::*;
#(
    parameter int ADDR_W     = 50,
    parameter int NUM_W64    = 16,
    parameter int PE_W       = 8,
    parameter int SEG_BITS   = 8,
    parameter int LG_W       = 6,
    parameter int W32_MIN_LG = 16,
    parameter int W32_MAX_LG = 32,
    parameter int W64_MIN_LG = 28,
    parameter int CA_W       = 10,
    parameter int CD_W       = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [CA_W-1:0]                   cfg_addr,
    input  logic [CD_W-1:0]                   cfg_wdata,
    input  logic [SEG_BITS-1:0]               tbl_idx,
    output logic [PE_W-1:0]                   tbl_pe,
    output logic                              w32_en,
    output logic [ADDR_W-1:0]                 w32_base,
    output logic [LG_W-1:0]                   w32_lg,
    output logic [31:0]                       w32_upper,
    output logic [NUM_W64-1:0]                w64_en,
    output logic [NUM_W64-1:0]                w64_segd,
    output logic [NUM_W64-1:0][LG_W-1:0]      w64_lg,
    output logic [NUM_W64-1:0][PE_W-1:0]      w64_pe,
    output logic [NUM_W64-1:0][ADDR_W-1:0]    w64_base
);
    localparam int SEGS  = 1 << SEG_BITS;
    localparam int IDX_W = $clog2(NUM_W64);

    logic [1:0]       space;
    logic [IDX_W-1:0] win_sel;
    logic             ctrl_sel;
    logic [LG_W-1:0]  wr_lg;
    logic [PE_W-1:0]  tbl_q [SEGS];

    function automatic logic [LG_W-1:0] clamp_lg(input logic [LG_W-1:0] v,
                                                 input int lo, input int hi);
        if (v < LG_W'(lo))      return LG_W'(lo);
        else if (v > LG_W'(hi)) return LG_W'(hi);
        else                    return v;
    endfunction

    always_comb begin
        space    = cfg_addr[CA_W-1 -: 2];
        win_sel  = cfg_addr[IDX_W:1];
        ctrl_sel = cfg_addr[0];
        wr_lg    = cfg_wdata[8 +: LG_W];
        tbl_pe   = tbl_q[tbl_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SEGS; k++) tbl_q[k] <= '0;
        end else if (cfg_we && space == SPACE_TBL) begin
            tbl_q[cfg_addr[SEG_BITS-1:0]] <= cfg_wdata[PE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w32_en    <= 1'b0;
            w32_base  <= '0;
            w32_lg    <= LG_W'(W32_MAX_LG);
            w32_upper <= '0;
        end else if (cfg_we && space == SPACE_W32) begin
            if (ctrl_sel) begin
                w32_en    <= cfg_wdata[0];
                w32_lg    <= clamp_lg(wr_lg, W32_MIN_LG, W32_MAX_LG);
                w32_upper <= cfg_wdata[63:32];
            end else begin
                w32_base  <= cfg_wdata[ADDR_W-1:0];
            end
        end
    end

    for (genvar n = 0; n < NUM_W64; n++) begin : g_w64
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                w64_en[n]   <= 1'b0;
                w64_segd[n] <= 1'b0;
                w64_lg[n]   <= LG_W'(W64_MIN_LG);
                w64_pe[n]   <= '0;
                w64_base[n] <= '0;
            end else if (cfg_we && space == SPACE_W64 && win_sel == IDX_W'(n)) begin
                if (ctrl_sel) begin
                    w64_en[n]   <= cfg_wdata[0];
                    w64_segd[n] <= cfg_wdata[1];
                    w64_lg[n]   <= clamp_lg(wr_lg, W64_MIN_LG, ADDR_W);
                    w64_pe[n]   <= cfg_wdata[16 +: PE_W];
                end else begin
                    w64_base[n] <= cfg_wdata[ADDR_W-1:0];
                end
            end
        end

        // R9: pass-through size never leaves its legal range
        p_w64_lg_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (w64_lg[n] >= LG_W'(W64_MIN_LG)) && (w64_lg[n] <= LG_W'(ADDR_W)));
    end

    // R5: translating window size stays within its legal range
    p_w32_lg_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (w32_lg >= LG_W'(W32_MIN_LG)) && (w32_lg <= LG_W'(W32_MAX_LG)));

endmodule

// File: rtl/mmio_win_match.sv
module mmio_win_match #(
    parameter int ADDR_W   = 50,
    parameter int LG_W     = 6,
    parameter int SEG_BITS = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                en,
    input  logic [ADDR_W-1:0]   base,
    input  logic [LG_W-1:0]     lg,
    output logic                hit,
    output logic [SEG_BITS-1:0] seg
);
    logic [ADDR_W-1:0] hi_mask;
    logic [ADDR_W-1:0] shifted;

    always_comb begin
        hi_mask = {ADDR_W{1'b1}} << lg;
        hit     = en && (((addr ^ base) & hi_mask) == '0);
        shifted = addr >> (lg - LG_W'(SEG_BITS));
        seg     = shifted[SEG_BITS-1:0];
    end

endmodule

// File: rtl/mmio_win_prio.sv
module mmio_win_prio #(
    parameter int NUM_W64  = 16,
    parameter int PE_W     = 8,
    parameter int SEG_BITS = 8,
    parameter int WID_W    = 5
) (
    input  logic                             hit32,
    input  logic [PE_W-1:0]                  tbl_pe,
    input  logic [NUM_W64-1:0]               hit64,
    input  logic [NUM_W64-1:0][SEG_BITS-1:0] seg64,
    input  logic [NUM_W64-1:0]               segd64,
    input  logic [NUM_W64-1:0][PE_W-1:0]     pe64,
    output logic                             any_hit,
    output logic                             is32,
    output logic [WID_W-1:0]                 win_id,
    output logic [PE_W-1:0]                  pe
);
    logic [WID_W-1:0] low_idx;

    always_comb begin
        low_idx = '0;
        for (int i = NUM_W64 - 1; i >= 0; i--) begin
            if (hit64[i]) low_idx = WID_W'(i);
        end
        any_hit = hit32 || (|hit64);
        is32    = hit32;
        win_id  = '0;
        pe      = '0;
        if (hit32) begin
            pe = tbl_pe;
        end else if (|hit64) begin
            win_id = low_idx + WID_W'(1);
            pe     = segd64[low_idx] ? PE_W'(seg64[low_idx]) : pe64[low_idx];
        end
    end

endmodule

// File: rtl/mmio_part_decoder.sv
module mmio_part_decoder
    import mmio_dec_pkg::*;
#(
    parameter int ADDR_W     = 50,
    parameter int NUM_W64    = 16,
    parameter int PE_W       = 8,
    parameter int SEG_BITS   = 8,
    parameter int BUS_W      = 64,
    parameter int CA_W       = 10,
    parameter int CD_W       = 64,
    localparam int WID_W     = $clog2(NUM_W64 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CA_W-1:0]   cfg_addr,
    input  logic [CD_W-1:0]   cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WID_W-1:0]  resp_win,
    output logic [PE_W-1:0]   resp_pe,
    output logic [BUS_W-1:0]  resp_bus_addr
);
    localparam int LG_W = $clog2(ADDR_W + 1);

    dec_state_e st_q, st_d;
    logic [ADDR_W-1:0] addr_q;

    logic                              w32_en;
    logic [ADDR_W-1:0]                 w32_base;
    logic [LG_W-1:0]                   w32_lg;
    logic [31:0]                       w32_upper;
    logic [NUM_W64-1:0]                w64_en;
    logic [NUM_W64-1:0]                w64_segd;
    logic [NUM_W64-1:0][LG_W-1:0]      w64_lg;
    logic [NUM_W64-1:0][PE_W-1:0]      w64_pe;
    logic [NUM_W64-1:0][ADDR_W-1:0]    w64_base;

    logic                              w32_hit;
    logic [SEG_BITS-1:0]               w32_seg;
    logic [PE_W-1:0]                   tbl_pe;
    logic [NUM_W64-1:0]                w64_hit;
    logic [NUM_W64-1:0][SEG_BITS-1:0]  w64_seg;

    logic              sel_hit, sel_is32;
    logic [WID_W-1:0]  sel_win;
    logic [PE_W-1:0]   sel_pe;
    logic [31:0]       keep_mask;
    logic [BUS_W-1:0]  bus_d;

    logic              hit_q;
    logic [WID_W-1:0]  win_q;
    logic [PE_W-1:0]   pe_q;
    logic [BUS_W-1:0]  bus_q;

    mmio_win_regs #(
        .ADDR_W(ADDR_W), .NUM_W64(NUM_W64), .PE_W(PE_W), .SEG_BITS(SEG_BITS),
        .LG_W(LG_W), .W32_MIN_LG(16), .W32_MAX_LG(32), .W64_MIN_LG(28),
        .CA_W(CA_W), .CD_W(CD_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tbl_idx(w32_seg), .tbl_pe(tbl_pe),
        .w32_en(w32_en), .w32_base(w32_base), .w32_lg(w32_lg),
        .w32_upper(w32_upper), .w64_en(w64_en), .w64_segd(w64_segd),
        .w64_lg(w64_lg), .w64_pe(w64_pe), .w64_base(w64_base)
    );

    mmio_win_match #(.ADDR_W(ADDR_W), .LG_W(LG_W), .SEG_BITS(SEG_BITS)) u_m32 (
        .addr(addr_q), .en(w32_en), .base(w32_base), .lg(w32_lg),
        .hit(w32_hit), .seg(w32_seg)
    );

    for (genvar n = 0; n < NUM_W64; n++) begin : g_m64
        mmio_win_match #(.ADDR_W(ADDR_W), .LG_W(LG_W), .SEG_BITS(SEG_BITS)) u_m (
            .addr(addr_q), .en(w64_en[n]), .base(w64_base[n]), .lg(w64_lg[n]),
            .hit(w64_hit[n]), .seg(w64_seg[n])
        );
    end

    mmio_win_prio #(.NUM_W64(NUM_W64), .PE_W(PE_W), .SEG_BITS(SEG_BITS), .WID_W(WID_W)) u_prio (
        .hit32(w32_hit), .tbl_pe(tbl_pe), .hit64(w64_hit), .seg64(w64_seg),
        .segd64(w64_segd), .pe64(w64_pe), .any_hit(sel_hit), .is32(sel_is32),
        .win_id(sel_win), .pe(sel_pe)
    );

    // bus address: translating window keeps the low bits and fills the rest
    always_comb begin
        keep_mask = 32'hFFFF_FFFF << w32_lg;
        if (!sel_hit)
            bus_d = '0;
        else if (sel_is32)
            bus_d = BUS_W'((w32_upper & keep_mask) | (addr_q[31:0] & ~keep_mask));
        else
            bus_d = BUS_W'(addr_q);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (req_valid) st_d = ST_DECODE;
            ST_DECODE: st_d = ST_REPLY;
            ST_REPLY:  st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready     = (st_q == ST_IDLE);
        resp_valid    = (st_q == ST_REPLY);
        resp_hit      = hit_q;
        resp_win      = win_q;
        resp_pe       = pe_q;
        resp_bus_addr = bus_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            hit_q  <= 1'b0;
            win_q  <= '0;
            pe_q   <= '0;
            bus_q  <= '0;
        end else begin
            if (st_q == ST_IDLE && req_valid) addr_q <= req_addr;
            if (st_q == ST_DECODE) begin
                hit_q <= sel_hit;
                win_q <= sel_hit ? sel_win : '0;
                pe_q  <= sel_hit ? sel_pe  : '0;
                bus_q <= bus_d;
            end
        end
    end

    // R2: single-cycle response pulse, two edges after acceptance
    p_resp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    p_resp_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid && req_ready, 2));
    // R11: a miss carries no partition, window or address
    p_miss_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_pe == '0 && resp_win == '0 && resp_bus_addr == '0));
    // R3: translating-window results are 32-bit bus addresses
    p_w32_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit && resp_win == '0) |-> (resp_bus_addr[BUS_W-1:32] == '0));
    // R6: pass-through results equal the request address
    p_w64_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit && resp_win != '0) |-> (resp_bus_addr == BUS_W'(addr_q)));
    // R10: translating window wins any overlap
    p_w32_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DECODE && w32_hit) |=> (resp_hit && resp_win == '0));
    // R10: pass-through window 0 beats every other pass-through window
    p_w64_low_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DECODE && !w32_hit && w64_hit[0]) |=> (resp_win == WID_W'(1)));

endmodule

// File: tb/sim_mmio_part_decoder.sv
`timescale 1ns/1ps
module sim_mmio_part_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [49:0] req_addr = '0;
    logic        req_ready, resp_valid, resp_hit;
    logic [4:0]  resp_win;
    logic [7:0]  resp_pe;
    logic [63:0] resp_bus_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    mmio_part_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_win(resp_win), .resp_pe(resp_pe), .resp_bus_addr(resp_bus_addr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic w32_set(input logic [49:0] base, input bit en, input int lg, input logic [31:0] up);
        wr(10'h100, 64'(base));
        wr(10'h101, {up, 18'd0, 6'(lg), 7'd0, en});
    endtask

    task automatic w64_set(input int n, input logic [49:0] base, input bit en, input bit segd,
                           input int lg, input logic [7:0] pe);
        wr(10'h200 | 10'(n << 1), 64'(base));
        wr(10'h201 | 10'(n << 1), {40'd0, pe, 2'd0, 6'(lg), 6'd0, segd, en});
    endtask

    task automatic lookup(input logic [49:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_hit(input string req, input logic [49:0] a, input int win,
                              input logic [7:0] pe, input logic [63:0] bus);
        lookup(a);
        check({req, " valid"}, 64'(resp_valid), 64'd1);
        check({req, " hit"}, 64'(resp_hit), 64'd1);
        check({req, " win"}, 64'(resp_win), 64'(win));
        check({req, " pe"}, 64'(resp_pe), 64'(pe));
        check({req, " bus"}, resp_bus_addr, bus);
    endtask

    task automatic expect_miss(input string req, input logic [49:0] a);
        lookup(a);
        check({req, " valid"}, 64'(resp_valid), 64'd1);
        check({req, " hit"}, 64'(resp_hit), 64'd0);
        check({req, " R11 pe"}, 64'(resp_pe), 64'd0);
        check({req, " R11 win"}, 64'(resp_win), 64'd0);
        check({req, " R11 bus"}, resp_bus_addr, 64'd0);
    endtask

    task automatic t_reset();
        check("R1 ready", 64'(req_ready), 64'd1);
        check("R1 resp_valid", 64'(resp_valid), 64'd0);
        expect_miss("R1 miss zero", 50'h0);
        expect_miss("R1 miss high", 50'h12_3456_7890);
    endtask

    task automatic t_w32();
        for (int k = 0; k < 256; k++) wr(10'(k), 64'(k ^ 8'h5A));
        w32_set(50'h3_8000_0000, 1'b1, 31, 32'h8000_0000);
        expect_hit("R3 R4 mid", 50'h3_9234_5678, 0, 8'h7E, 64'h9234_5678);
        expect_hit("R3 R4 last seg", 50'h3_FFFF_FFFF, 0, 8'hA5, 64'hFFFF_FFFF);
        expect_miss("R11 above w32", 50'h4_0000_0000);
    endtask

    task automatic t_w32_clamp();
        w32_set(50'h1_0000_0000, 1'b1, 40, 32'hABCD_0000);
        expect_hit("R5 clamp high", 50'h1_FFFF_FFFF, 0, 8'hA5, 64'hFFFF_FFFF);
        expect_miss("R5 clamp high edge", 50'h2_0000_0000);
        w32_set(50'h1_0000_0000, 1'b1, 3, 32'hABCD_0000);
        expect_hit("R5 R3 clamp low", 50'h1_0000_FFFF, 0, 8'hA5, 64'hABCD_FFFF);
        expect_miss("R5 clamp low edge", 50'h1_0001_0000);
        w32_set(50'h1_0000_0000, 1'b0, 16, 32'hABCD_0000);
        expect_miss("R13 w32 disabled", 50'h1_0000_0010);
    endtask

    task automatic t_w64();
        w64_set(3, 50'h10_0000_0000, 1'b1, 1'b1, 36, 8'h00);
        expect_hit("R6 R7 segmented", 50'h15_2000_1234, 4, 8'h52, 64'h15_2000_1234);
        w64_set(5, 50'h20_0000_0000, 1'b1, 1'b0, 30, 8'h33);
        expect_hit("R8 unsegmented", 50'h20_3FFF_FFF0, 6, 8'h33, 64'h20_3FFF_FFF0);
        w64_set(7, 50'h30_0000_0000, 1'b1, 1'b0, 10, 8'h44);
        expect_hit("R9 clamp", 50'h30_0FFF_FFFF, 8, 8'h44, 64'h30_0FFF_FFFF);
        expect_miss("R9 clamp edge", 50'h30_1000_0000);
        w64_set(8, 50'h40_0123_4567, 1'b1, 1'b0, 32, 8'h11);
        expect_hit("R12 low base", 50'h40_0000_0000, 9, 8'h11, 64'h40_0000_0000);
        expect_hit("R12 top", 50'h40_FFFF_FFFF, 9, 8'h11, 64'h40_FFFF_FFFF);
        expect_miss("R12 above", 50'h41_0000_0000);
    endtask

    task automatic t_prio();
        w64_set(2, 50'h12_0000_0000, 1'b1, 1'b0, 32, 8'h22);
        expect_hit("R10 low index", 50'h12_0000_0010, 3, 8'h22, 64'h12_0000_0010);
        w32_set(50'h12_0000_0000, 1'b1, 31, 32'h0);
        expect_hit("R10 w32 first", 50'h12_0000_0010, 0, 8'h5A, 64'h10);
        w64_set(2, 50'h12_0000_0000, 1'b0, 1'b0, 32, 8'h22);
        expect_hit("R13 fall through", 50'h12_8000_0010, 4, 8'h28, 64'h12_8000_0010);
    endtask

    task automatic t_busy();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 50'h15_2000_1234;
        @(negedge clk);
        check("R2 not ready in decode", 64'(req_ready), 64'd0);
        check("R2 no early resp", 64'(resp_valid), 64'd0);
        req_addr = 50'h20_0000_0000;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 resp", 64'(resp_valid), 64'd1);
        check("R2 first req kept", 64'(resp_win), 64'd4);
        check("R2 not ready in reply", 64'(req_ready), 64'd0);
        @(negedge clk);
        check("R2 pulse ends", 64'(resp_valid), 64'd0);
        check("R2 ready again", 64'(req_ready), 64'd1);
        @(negedge clk);
        check("R2 ignored req", 64'(resp_valid), 64'd0);
        @(negedge clk);
        check("R2 ignored req later", 64'(resp_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_w32();
        t_w32_clamp();
        t_w64();
        t_prio();
        t_busy();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule